// File: doc/BRIEF.md
# Multichannel SPI Interrupt Status Unit

This block holds the shared interrupt state of a four-channel SPI controller. Each channel engine sends two kinds of one-cycle event pulses: one when its transmit holding slot empties and one when its receive slot fills. The unit latches these events into a sticky status word. A software-programmed enable word masks the status word, and the result drives one registered, level-sensitive interrupt line. The same register port also holds the wakeup enable, the system-test word, the module-control word and the system configuration word, and it returns fixed identification values.

A test mode exists for checking the interrupt path without any channel traffic. When module-control bit 3 and system-test bit 11 are both set, every implemented status bit is forced to 1. While both bits stay set, software writes to the status word cannot clear anything. A soft reset can come from a dedicated input or from a configuration write. It returns the whole register set to its initial state.

The register port has a single-cycle write strobe and a read strobe. Read data appears on the cycle after the read strobe.

Top module: `spi_irq_unit`

## Requirements
- R1: `irq_o` is a register. It is high on the cycle after any cycle in which (status AND enable) is nonzero, so it follows a status or enable change one cycle later.
- R2: A transmit-empty pulse on channel n sets status bit 4*n. A receive-full pulse on channel n sets status bit 4*n+2. Both bits stay set until they are cleared.
- R3: A write to the status word (offset 0x18) clears each bit where the write data holds a 1. The whole write is ignored while module-control bit 3 and system-test bit 11 are both set.
- R4: The enable word (offset 0x1C) stores only the bits in mask 0x1777F. The wakeup word (offset 0x20) stores only bit 0.
- R5: A write to system-test (offset 0x24) with bit 11 set, while module-control bit 3 is already set, forces all status bits in mask 0x1777F to 1. System-test stores only its low 12 bits.
- R6: A write to module-control (offset 0x28) with bit 3 set, while system-test bit 11 is already set, forces the same status bits. Module-control stores only its low 4 bits.
- R7: A pulse on `soft_rst_i` clears status, enable, wakeup, system-test and configuration, and loads module-control with 4. Hardware reset leaves the same values, with `irq_o` and `reg_rdata_o` at 0.
- R8: A write to configuration (offset 0x10) with bit 1 set performs the soft reset of R7. In every case the configuration word then holds the written value ANDed with 0x31D.
- R9: Reads at offset 0x00 return 0x91, reads at offset 0x14 return 1, and reads at any unmapped offset return 0. The data appears on the cycle after `reg_rd_i`.
- R10: When an event pulse and a software clear target the same status bit in one cycle, the bit ends up set. Other bits in the same clear are still cleared.
- R11: When a soft reset and an event pulse fall in the same cycle, the soft reset wins and status ends up at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst_i | input | 1 | One-cycle soft reset request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after `reg_rd_i` |
| tx_empty_evt_i | input | NUM_CH | Per-channel transmit-empty event pulses |
| rx_full_evt_i | input | NUM_CH | Per-channel receive-full event pulses |
| irq_o | output | 1 | Registered level interrupt |

## Verification
Two functions can land in the same cycle: the event-driven setting of a status bit, and either a software clear of that bit or a soft reset. The bench provokes each collision by raising an event pulse in the same clock cycle as a clear-by-one write, or as a `soft_rst_i` pulse. It then reads the status word back through the port. After a collision with a clear, it expects the colliding bit to be set and a second bit in the same clear to be gone. After a collision with a soft reset, it expects zero. The registered interrupt line is checked one cycle after each change, on both its rising and its falling edge.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int REG_W = 32;

  // register byte offsets
  localparam logic [7:0] OFS_REV   = 8'h00;
  localparam logic [7:0] OFS_CFG   = 8'h10;
  localparam logic [7:0] OFS_SYSST = 8'h14;
  localparam logic [7:0] OFS_STS   = 8'h18;
  localparam logic [7:0] OFS_EN    = 8'h1C;
  localparam logic [7:0] OFS_WAKE  = 8'h20;
  localparam logic [7:0] OFS_TEST  = 8'h24;
  localparam logic [7:0] OFS_MODE  = 8'h28;

  // storage masks and constant values
  localparam logic [REG_W-1:0] IRQ_MASK  = 32'h0001_777F;
  localparam logic [REG_W-1:0] CFG_MASK  = 32'h0000_031D;
  localparam logic [REG_W-1:0] TEST_MASK = 32'h0000_0FFF;
  localparam logic [REG_W-1:0] MODE_MASK = 32'h0000_000F;
  localparam logic [REG_W-1:0] WAKE_MASK = 32'h0000_0001;
  localparam logic [REG_W-1:0] REV_VAL   = 32'h0000_0091;
  localparam logic [REG_W-1:0] SYSST_VAL = 32'h0000_0001;
  localparam logic [REG_W-1:0] MODE_RST  = 32'h0000_0004;

  // control bit positions
  localparam int MODE_TEST_BIT  = 3;
  localparam int TEST_FORCE_BIT = 11;
  localparam int CFG_SRST_BIT   = 1;

  // per-channel status lane layout
  localparam int LANE_STRIDE = 4;
  localparam int TX_LANE_OFS = 0;
  localparam int RX_LANE_OFS = 2;
endpackage

// File: rtl/spi_irq_evt_map.sv
module spi_irq_evt_map
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] tx_evt_i,
  input  logic [NUM_CH-1:0] rx_evt_i,
  output logic [REG_W-1:0]  set_vec_o
);
  localparam int TOP_BIT = LANE_STRIDE * (NUM_CH - 1) + RX_LANE_OFS;

  initial begin
    if (TOP_BIT >= REG_W) $error("NUM_CH too large for status width");
  end

  logic [NUM_CH-1:0][REG_W-1:0] lane_vec;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    always_comb begin
      lane_vec[ch] = '0;
      lane_vec[ch][LANE_STRIDE*ch + TX_LANE_OFS] = tx_evt_i[ch];
      lane_vec[ch][LANE_STRIDE*ch + RX_LANE_OFS] = rx_evt_i[ch];
    end
  end

  always_comb begin
    set_vec_o = '0;
    for (int ch = 0; ch < NUM_CH; ch++) set_vec_o = set_vec_o | lane_vec[ch];
  end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  cfg_q,
  output logic [REG_W-1:0]  en_q,
  output logic [REG_W-1:0]  wake_q,
  output logic [REG_W-1:0]  test_q,
  output logic [REG_W-1:0]  mode_q,
  output logic              sreset_o,
  output logic              force_o,
  output logic              lock_o,
  output logic [REG_W-1:0]  clr_vec_o
);
  logic hit_cfg, hit_sts, hit_en, hit_wake, hit_test, hit_mode;

  assign hit_cfg  = wr_i && (addr_i == ADDR_W'(OFS_CFG));
  assign hit_sts  = wr_i && (addr_i == ADDR_W'(OFS_STS));
  assign hit_en   = wr_i && (addr_i == ADDR_W'(OFS_EN));
  assign hit_wake = wr_i && (addr_i == ADDR_W'(OFS_WAKE));
  assign hit_test = wr_i && (addr_i == ADDR_W'(OFS_TEST));
  assign hit_mode = wr_i && (addr_i == ADDR_W'(OFS_MODE));

  assign sreset_o  = soft_rst_i || (hit_cfg && wdata_i[CFG_SRST_BIT]);
  assign lock_o    = mode_q[MODE_TEST_BIT] && test_q[TEST_FORCE_BIT];
  assign force_o   = (hit_test && wdata_i[TEST_FORCE_BIT] && mode_q[MODE_TEST_BIT]) ||
                     (hit_mode && wdata_i[MODE_TEST_BIT] && test_q[TEST_FORCE_BIT]);
  assign clr_vec_o = (hit_sts && !lock_o) ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      en_q   <= '0;
      wake_q <= '0;
      test_q <= '0;
      mode_q <= MODE_RST;
    end else begin
      if (sreset_o) begin
        cfg_q  <= '0;
        en_q   <= '0;
        wake_q <= '0;
        test_q <= '0;
        mode_q <= MODE_RST;
      end else begin
        if (hit_en)   en_q   <= wdata_i & IRQ_MASK;
        if (hit_wake) wake_q <= wdata_i & WAKE_MASK;
        if (hit_test) test_q <= wdata_i & TEST_MASK;
        if (hit_mode) mode_q <= wdata_i & MODE_MASK;
      end
      if (hit_cfg) cfg_q <= wdata_i & CFG_MASK;
    end
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sreset_i,
  input  logic             force_i,
  input  logic [REG_W-1:0] set_vec_i,
  input  logic [REG_W-1:0] clr_vec_i,
  output logic [REG_W-1:0] sts_q
);
  logic [REG_W-1:0] force_vec;
  logic [REG_W-1:0] sts_d;

  assign force_vec = force_i ? IRQ_MASK : '0;

  always_comb begin
    if (sreset_i) sts_d = '0;
    else          sts_d = ((sts_q & ~clr_vec_i) | set_vec_i | force_vec) & IRQ_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) sts_q <= '0;
    else     sts_q <= sts_d;
  end
endmodule

// File: rtl/spi_irq_rdmux.sv
module spi_irq_rdmux
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  cfg_i,
  input  logic [REG_W-1:0]  sts_i,
  input  logic [REG_W-1:0]  en_i,
  input  logic [REG_W-1:0]  wake_i,
  input  logic [REG_W-1:0]  test_i,
  input  logic [REG_W-1:0]  mode_i,
  output logic [REG_W-1:0]  rdata_q
);
  logic [REG_W-1:0] rd_sel;

  always_comb begin
    rd_sel = '0;
    if      (addr_i == ADDR_W'(OFS_REV))   rd_sel = REV_VAL;
    else if (addr_i == ADDR_W'(OFS_CFG))   rd_sel = cfg_i;
    else if (addr_i == ADDR_W'(OFS_SYSST)) rd_sel = SYSST_VAL;
    else if (addr_i == ADDR_W'(OFS_STS))   rd_sel = sts_i;
    else if (addr_i == ADDR_W'(OFS_EN))    rd_sel = en_i;
    else if (addr_i == ADDR_W'(OFS_WAKE))  rd_sel = wake_i;
    else if (addr_i == ADDR_W'(OFS_TEST))  rd_sel = test_i;
    else if (addr_i == ADDR_W'(OFS_MODE))  rd_sel = mode_i;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_sel;
  end
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [NUM_CH-1:0] tx_empty_evt_i,
  input  logic [NUM_CH-1:0] rx_full_evt_i,
  output logic              irq_o
);
  logic [REG_W-1:0] set_vec, clr_vec, sts_q;
  logic [REG_W-1:0] cfg_q, en_q, wake_q, test_q, mode_q;
  logic             sreset, force_all, lock;
  logic             irq_q;

  spi_irq_evt_map #(.NUM_CH(NUM_CH)) u_map (
    .tx_evt_i  (tx_empty_evt_i),
    .rx_evt_i  (rx_full_evt_i),
    .set_vec_o (set_vec)
  );

  spi_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .soft_rst_i (soft_rst_i),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .cfg_q      (cfg_q),
    .en_q       (en_q),
    .wake_q     (wake_q),
    .test_q     (test_q),
    .mode_q     (mode_q),
    .sreset_o   (sreset),
    .force_o    (force_all),
    .lock_o     (lock),
    .clr_vec_o  (clr_vec)
  );

  spi_irq_status u_sts (
    .clk       (clk),
    .rst       (rst),
    .sreset_i  (sreset),
    .force_i   (force_all),
    .set_vec_i (set_vec),
    .clr_vec_i (clr_vec),
    .sts_q     (sts_q)
  );

  spi_irq_rdmux #(.ADDR_W(ADDR_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_i    (reg_rd_i),
    .addr_i  (reg_addr_i),
    .cfg_i   (cfg_q),
    .sts_i   (sts_q),
    .en_i    (en_q),
    .wake_i  (wake_q),
    .test_i  (test_q),
    .mode_i  (mode_q),
    .rdata_q (reg_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(sts_q & en_q);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/spi_irq_unit_chk.sv
module spi_irq_unit_chk
  import spi_irq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic [REG_W-1:0] sts,
  input logic [REG_W-1:0] en,
  input logic [REG_W-1:0] mode,
  input logic [REG_W-1:0] set_vec,
  input logic             sreset,
  input logic             force_all,
  input logic             lock
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  assert_irq_follows_R1: assert property (@(posedge clk) disable iff (rst)
    armed |-> (irq == (|($past(sts) & $past(en)))));

  // also covers R10: an event sets its bit even when cleared in the same cycle
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && (set_vec != '0) && !sreset) |=> ((sts & $past(set_vec)) == $past(set_vec)));

  assert_lock_no_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && lock && !sreset) |=> (($past(sts) & ~sts) == '0));

  assert_force_all_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && force_all && !sreset) |=> ((sts & IRQ_MASK) == IRQ_MASK));

  assert_soft_reset_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && sreset) |=> ((sts == '0) && (en == '0) && (mode == MODE_RST)));
endmodule

bind spi_irq_unit spi_irq_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq       (irq_o),
  .sts       (sts_q),
  .en        (en_q),
  .mode      (mode_q),
  .set_vec   (set_vec),
  .sreset    (sreset),
  .force_all (force_all),
  .lock      (lock)
);

// File: tb/tb_spi_irq_unit.sv
module tb_spi_irq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 8;
  localparam int NV = 39;

  // entry: [44] read(1)/write(0), [43:40] requirement, [39:32] offset, [31:0] data or expected
  localparam logic [44:0] VEC [0:NV-1] = '{
    {1'b1, 4'd9, 8'h00, 32'h0000_0091},  // R9 revision
    {1'b1, 4'd9, 8'h14, 32'h0000_0001},  // R9 system status
    {1'b1, 4'd9, 8'h2C, 32'h0000_0000},  // R9 unmapped
    {1'b1, 4'd7, 8'h28, 32'h0000_0004},  // R7 mode reset value
    {1'b1, 4'd7, 8'h18, 32'h0000_0000},  // R7
    {1'b1, 4'd7, 8'h1C, 32'h0000_0000},  // R7
    {1'b0, 4'd4, 8'h1C, 32'hFFFF_FFFF},
    {1'b1, 4'd4, 8'h1C, 32'h0001_777F},  // R4 enable mask
    {1'b0, 4'd4, 8'h20, 32'hFFFF_FFFF},
    {1'b1, 4'd4, 8'h20, 32'h0000_0001},  // R4 wake bit
    {1'b0, 4'd5, 8'h24, 32'h0001_2345},
    {1'b1, 4'd5, 8'h24, 32'h0000_0345},  // R5 low 12 bits
    {1'b0, 4'd6, 8'h28, 32'h0000_00FF},
    {1'b1, 4'd6, 8'h28, 32'h0000_000F},  // R6 low 4 bits
    {1'b1, 4'd6, 8'h18, 32'h0000_0000},  // R6 no force without test bit 11
    {1'b0, 4'd5, 8'h24, 32'h0000_0800},
    {1'b1, 4'd5, 8'h18, 32'h0001_777F},  // R5 forced
    {1'b1, 4'd5, 8'h24, 32'h0000_0800},
    {1'b0, 4'd3, 8'h18, 32'hFFFF_FFFF},
    {1'b1, 4'd3, 8'h18, 32'h0001_777F},  // R3 clear blocked
    {1'b0, 4'd3, 8'h28, 32'h0000_0000},
    {1'b0, 4'd3, 8'h18, 32'h0000_000F},
    {1'b1, 4'd3, 8'h18, 32'h0001_7770},  // R3 clear by ones
    {1'b0, 4'd3, 8'h18, 32'hFFFF_FFFF},
    {1'b1, 4'd3, 8'h18, 32'h0000_0000},  // R3
    {1'b0, 4'd6, 8'h28, 32'h0000_0008},
    {1'b1, 4'd6, 8'h18, 32'h0001_777F},  // R6 forced by mode write
    {1'b0, 4'd8, 8'h10, 32'h0000_FFFF},
    {1'b1, 4'd8, 8'h10, 32'h0000_031D},  // R8 stored masked
    {1'b1, 4'd8, 8'h28, 32'h0000_0004},  // R8 reset happened
    {1'b1, 4'd8, 8'h18, 32'h0000_0000},
    {1'b1, 4'd8, 8'h1C, 32'h0000_0000},
    {1'b1, 4'd8, 8'h24, 32'h0000_0000},
    {1'b1, 4'd8, 8'h20, 32'h0000_0000},
    {1'b0, 4'd8, 8'h1C, 32'h0000_0005},
    {1'b0, 4'd8, 8'h10, 32'h0000_0001},
    {1'b1, 4'd8, 8'h1C, 32'h0000_0005},  // R8 no reset without bit 1
    {1'b1, 4'd8, 8'h10, 32'h0000_0001},
    {1'b0, 4'd1, 8'h1C, 32'h0000_0000}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              soft_rst_i = 1'b0;
  logic              reg_wr_i = 1'b0;
  logic              reg_rd_i = 1'b0;
  logic [ADDR_W-1:0] reg_addr_i = '0;
  logic [31:0]       reg_wdata_i = '0;
  logic [31:0]       reg_rdata_o;
  logic [NUM_CH-1:0] tx_empty_evt_i = '0;
  logic [NUM_CH-1:0] rx_full_evt_i = '0;
  logic              irq_o;

  int checks = 0;
  int errors = 0;

  spi_irq_unit #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut (
    .clk            (clk),
    .rst            (rst),
    .soft_rst_i     (soft_rst_i),
    .reg_wr_i       (reg_wr_i),
    .reg_rd_i       (reg_rd_i),
    .reg_addr_i     (reg_addr_i),
    .reg_wdata_i    (reg_wdata_i),
    .reg_rdata_o    (reg_rdata_o),
    .tx_empty_evt_i (tx_empty_evt_i),
    .rx_full_evt_i  (rx_full_evt_i),
    .irq_o          (irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // one clock of stimulus; called just after a falling edge, returns after the next one
  task automatic step(input logic wr, input logic rd, input logic [7:0] addr,
                      input logic [31:0] data, input logic [NUM_CH-1:0] tx,
                      input logic [NUM_CH-1:0] rx, input logic srst);
    reg_wr_i = wr; reg_rd_i = rd; reg_addr_i = addr; reg_wdata_i = data;
    tx_empty_evt_i = tx; rx_full_evt_i = rx; soft_rst_i = srst;
    @(posedge clk);
    @(negedge clk);
    reg_wr_i = 1'b0; reg_rd_i = 1'b0; tx_empty_evt_i = '0; rx_full_evt_i = '0; soft_rst_i = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] addr, input logic [31:0] exp);
    step(1'b0, 1'b1, addr, 32'h0, '0, '0, 1'b0);
    check(req, reg_rdata_o, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset irq", {31'b0, irq_o}, 32'h0);
    check("R7 reset rdata", reg_rdata_o, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) begin
        step(1'b0, 1'b1, VEC[i][39:32], 32'h0, '0, '0, 1'b0);
        check($sformatf("R%0d vector %0d", VEC[i][43:40], i), reg_rdata_o, VEC[i][31:0]);
      end else begin
        step(1'b1, 1'b0, VEC[i][39:32], VEC[i][31:0], '0, '0, 1'b0);
      end
    end

    // R2: each event lands in its own status bit
    for (int n = 0; n < NUM_CH; n++) begin
      step(1'b0, 1'b0, 8'h00, 32'h0, NUM_CH'(1 << n), '0, 1'b0);
      rd_check("R2 tx lane", 8'h18, 32'h1 << (4*n));
      step(1'b1, 1'b0, 8'h18, 32'hFFFF_FFFF, '0, '0, 1'b0);
      step(1'b0, 1'b0, 8'h00, 32'h0, '0, NUM_CH'(1 << n), 1'b0);
      rd_check("R2 rx lane", 8'h18, 32'h1 << (4*n + 2));
      step(1'b1, 1'b0, 8'h18, 32'hFFFF_FFFF, '0, '0, 1'b0);
    end
    check("R1 masked off", {31'b0, irq_o}, 32'h0);

    // R1: irq timing, one cycle behind status and enable
    step(1'b1, 1'b0, 8'h1C, 32'h0000_0040, '0, '0, 1'b0);
    step(1'b0, 1'b0, 8'h00, 32'h0, '0, 4'b0010, 1'b0);
    check("R1 not yet", {31'b0, irq_o}, 32'h0);
    step(1'b0, 1'b0, 8'h00, 32'h0, '0, '0, 1'b0);
    check("R1 rise", {31'b0, irq_o}, 32'h1);
    step(1'b1, 1'b0, 8'h18, 32'h0000_0040, '0, '0, 1'b0);
    check("R1 still high", {31'b0, irq_o}, 32'h1);
    step(1'b0, 1'b0, 8'h00, 32'h0, '0, '0, 1'b0);
    check("R1 fall", {31'b0, irq_o}, 32'h0);

    // R10: event beats a clear of the same bit, other bits still clear
    step(1'b0, 1'b0, 8'h00, 32'h0, 4'b0011, '0, 1'b0);
    rd_check("R10 setup", 8'h18, 32'h0000_0011);
    step(1'b1, 1'b0, 8'h18, 32'h0000_0011, 4'b0001, '0, 1'b0);
    rd_check("R10 event wins", 8'h18, 32'h0000_0001);

    // R11: soft reset beats an event
    step(1'b0, 1'b0, 8'h00, 32'h0, '0, 4'b1000, 1'b1);
    rd_check("R11 status", 8'h18, 32'h0);
    rd_check("R11 mode", 8'h28, 32'h4);
    rd_check("R11 config", 8'h10, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule